// File: doc/BRIEF.md
# Stepper Positioner Phase Sequencer

This block drives the four phase windings of a head-positioning stepper motor from an interface step pulse and a direction level. When idle it holds the motor on phase 4 with full holding current. A qualified step pulse starts a three-stage phase walk that is clocked by an internal gated oscillator, and the walk always returns to phase 4. The direction level, captured when the step is accepted, decides the order of the stages.

For the whole walk a busy flag is raised, and the write path uses it to block writing. The full holding drive is switched off while the motor moves. If no further step is accepted within a set window after the last one, the block drops to a reduced holding drive of about half current to save power. The next accepted step brings back full hold. All durations are parameters given in clock cycles.

Top module: `stepper_phase_seq`

## Requirements
- R1: A synchronous active-high reset leaves the block at rest: `phase_en` = 4'b1000 (phase 4), `step_busy` = 0, `hold_full` = 1, `hold_low` = 0. The idle timer restarts on the reset cycle.
- R2: A step is accepted on the first clock edge at which `step_pulse` samples 0 after sampling 1 on the edge before (the trailing edge). At that edge `drv_sel` must be 1 and `wr_gate` must be 0. A pulse that fails this qualification has no effect on any output.
- R3: `step_busy` rises at the accepting edge and stays high for exactly 3*STAGE_CYC cycles. The phase sequence then returns to rest.
- R4: With `step_dir` = 0 at acceptance (inward), the phases run phase 1 (4'b0001), phase 2 (4'b0010), phase 3 (4'b0100), STAGE_CYC cycles each, and then return to phase 4.
- R5: With `step_dir` = 1 at acceptance (outward), the phases run phase 3, phase 2, phase 1, STAGE_CYC cycles each, and then return to phase 4. A later change of `step_dir` does not alter a sequence already running.
- R6: A step trailing edge that arrives while `step_busy` is high is ignored.
- R7: `hold_full` is 0 whenever `step_busy` is 1.
- R8: If HOLD_CYC clock edges pass after the last accepted step (or after reset) with no new accepted step, `hold_full` goes to 0 and `hold_low` goes to 1.
- R9: An accepted step clears `hold_low` and restarts the idle timer. When the step is done, `hold_full` returns to 1.
- R10: Exactly one bit of `phase_en` is set in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_pulse | input | 1 | Step request pulse, active high, acted on at its trailing edge |
| step_dir | input | 1 | Direction level: 0 inward, 1 outward |
| drv_sel | input | 1 | Drive selected |
| wr_gate | input | 1 | Write in progress |
| phase_en | output | 4 | One-hot phase winding enables, bit i drives phase i+1 |
| hold_full | output | 1 | Full holding current enable |
| hold_low | output | 1 | Reduced holding current enable |
| step_busy | output | 1 | Step in progress, write inhibit |

## Verification
Directed steps in both directions check the inward and outward phase orders, which tell apart a correct mux from one with the order swapped. A direction flip during a walk shows whether the direction is latched at acceptance. Pulses sent while deselected, while writing, and while busy, along with long and back-to-back pulses, separate trailing-edge acceptance from leading-edge acceptance and show whether each qualifier is honoured. Idle gaps longer than the hold window, followed by a new step, check the fall-back to reduced hold and the return to full hold. A long run of seeded random pulse widths, gaps and qualifier levels is compared cycle by cycle against a bench timing model.

// File: rtl/stpseq_pkg.sv
package stpseq_pkg;

    typedef enum logic [1:0] {
        SEQ_REST = 2'd0,
        SEQ_A    = 2'd1,
        SEQ_B    = 2'd2,
        SEQ_C    = 2'd3
    } seq_t;

    localparam int NUM_PHASES = 4;
    localparam int NUM_STAGES = 3;

    typedef struct packed {
        logic busy;
        logic outward;
        seq_t seq;
    } seq_state_t;

    function automatic seq_t seq_next(input seq_t s);
        case (s)
            SEQ_A:   return SEQ_B;
            SEQ_B:   return SEQ_C;
            default: return SEQ_REST;
        endcase
    endfunction

    function automatic logic [NUM_PHASES-1:0] phase_map(input seq_t s, input logic outward);
        case (s)
            SEQ_A:   return outward ? 4'b0100 : 4'b0001;
            SEQ_B:   return 4'b0010;
            SEQ_C:   return outward ? 4'b0001 : 4'b0100;
            default: return 4'b1000;
        endcase
    endfunction

endpackage

// File: rtl/stp_trigger.sv
module stp_trigger (
    input  logic clk,
    input  logic rst,
    input  logic step_pulse,
    input  logic drv_sel,
    input  logic wr_gate,
    input  logic busy,
    output logic accept
);
    logic step_q;
    logic trail;

    always_ff @(posedge clk) begin
        if (rst) step_q <= 1'b0;
        else     step_q <= step_pulse;
    end

    assign trail  = step_q & ~step_pulse;
    assign accept = trail & drv_sel & ~wr_gate & ~busy;

    // R2: acceptance only follows a high-then-low pulse with select and no write
    assert_accept_qual_R2: assert property (@(posedge clk) disable iff (rst)
        accept |-> ($past(step_pulse) && !step_pulse && drv_sel && !wr_gate));

endmodule

// File: rtl/stp_sequencer.sv
module stp_sequencer
    import stpseq_pkg::*;
#(
    parameter int STAGE_CYC = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  logic       step_dir,
    output seq_state_t state
);
    localparam int CW       = (STAGE_CYC > 1) ? $clog2(STAGE_CYC) : 1;
    localparam int BUSY_CYC = NUM_STAGES * STAGE_CYC;

    logic [CW-1:0] osc_cnt;
    logic          osc_tick;

    // gated oscillator: runs only while busy
    assign osc_tick = state.busy && (osc_cnt == CW'(STAGE_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            osc_cnt <= '0;
            state   <= '{busy: 1'b0, outward: 1'b0, seq: SEQ_REST};
        end else if (accept) begin
            osc_cnt <= '0;
            state   <= '{busy: 1'b1, outward: step_dir, seq: SEQ_A};
        end else if (state.busy) begin
            if (osc_tick) begin
                osc_cnt    <= '0;
                state.seq  <= seq_next(state.seq);
                state.busy <= (state.seq != SEQ_C);
            end else begin
                osc_cnt <= osc_cnt + 1'b1;
            end
        end else begin
            osc_cnt <= '0;
        end
    end

    // checker counter for the busy window length
    int busy_len;
    always_ff @(posedge clk) begin
        if (rst)             busy_len <= 0;
        else if (state.busy) busy_len <= busy_len + 1;
        else                 busy_len <= 0;
    end

    initial begin
        assert_stage_len_R3: assert (STAGE_CYC >= 2);
    end

    // R3: busy window lasts exactly three stages
    assert_busy_len_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(state.busy) |-> (busy_len == BUSY_CYC));
    // R6: no step is taken while a walk is running
    assert_no_accept_busy_R6: assert property (@(posedge clk) disable iff (rst)
        accept |-> !state.busy);
    // R5: direction is held for the whole walk
    assert_dir_stable_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(state.busy) && state.busy && !$past(accept)) |-> $stable(state.outward));
    // R3: rest state and busy agree
    assert_rest_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (state.seq == SEQ_REST) |-> !state.busy);

endmodule

// File: rtl/stp_hold.sv
module stp_hold #(
    parameter int HOLD_CYC = 80
) (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic busy,
    output logic hold_full,
    output logic hold_low
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] idle_cnt;
    logic          expired;

    always_ff @(posedge clk) begin
        if (rst || accept)       idle_cnt <= '0;
        else if (!expired)       idle_cnt <= idle_cnt + 1'b1;
    end

    assign expired   = (idle_cnt == HW'(HOLD_CYC));
    assign hold_low  = expired;
    assign hold_full = ~busy & ~expired;

    // R7: full hold is off while stepping
    assert_full_off_busy_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> !hold_full);
    // R9: an accepted step leaves reduced hold
    assert_accept_clears_low_R9: assert property (@(posedge clk) disable iff (rst)
        accept |=> !hold_low);
    // R8: both hold drives never on together
    assert_hold_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(hold_full && hold_low));
    // R8: reduced hold never starts during a walk
    assert_low_idle_R8: assert property (@(posedge clk) disable iff (rst)
        hold_low |-> !busy);

endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
    import stpseq_pkg::*;
#(
    parameter int STAGE_CYC = 16,
    parameter int HOLD_CYC  = 80
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       step_pulse,
    input  logic       step_dir,
    input  logic       drv_sel,
    input  logic       wr_gate,
    output logic [3:0] phase_en,
    output logic       hold_full,
    output logic       hold_low,
    output logic       step_busy
);
    seq_state_t st;
    logic       accept;
    logic [NUM_PHASES-1:0] pmap;

    stp_trigger u_trig (
        .clk        (clk),
        .rst        (rst),
        .step_pulse (step_pulse),
        .drv_sel    (drv_sel),
        .wr_gate    (wr_gate),
        .busy       (st.busy),
        .accept     (accept)
    );

    stp_sequencer #(.STAGE_CYC(STAGE_CYC)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .step_dir (step_dir),
        .state    (st)
    );

    stp_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .busy      (st.busy),
        .hold_full (hold_full),
        .hold_low  (hold_low)
    );

    assign pmap = phase_map(st.seq, st.outward);

    for (genvar i = 0; i < NUM_PHASES; i++) begin : g_phase
        assign phase_en[i] = pmap[i];
    end

    assign step_busy = st.busy;

    initial begin
        assert_hold_window_R8: assert (HOLD_CYC > NUM_STAGES * STAGE_CYC);
    end

    // R10: exactly one winding energized
    assert_one_phase_R10: assert property (@(posedge clk) disable iff (rst)
        $countones(phase_en) == 1);
    // R1: idle means phase 4
    assert_rest_phase4_R1: assert property (@(posedge clk) disable iff (rst)
        !step_busy |-> (phase_en == 4'b1000));
    // R4: the first stage of a walk leaves phase 4
    assert_first_stage_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(step_busy) |-> !phase_en[3]);

endmodule

// File: tb/tb_stepper_phase_seq.sv
`timescale 1ns/1ps
module tb_stepper_phase_seq;
    localparam int S    = 16;
    localparam int HOLD = 80;
    localparam int BUSY = 3 * S;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step_pulse = 1'b0, step_dir = 1'b0, drv_sel = 1'b0, wr_gate = 1'b0;
    logic [3:0] phase_en;
    logic hold_full, hold_low, step_busy;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int   bt, it;
    logic prev, dirl;

    always #2.5 clk = ~clk;

    stepper_phase_seq #(.STAGE_CYC(S), .HOLD_CYC(HOLD)) dut (
        .clk(clk), .rst(rst), .step_pulse(step_pulse), .step_dir(step_dir),
        .drv_sel(drv_sel), .wr_gate(wr_gate), .phase_en(phase_en),
        .hold_full(hold_full), .hold_low(hold_low), .step_busy(step_busy)
    );

    function automatic logic exp_busy();
        return bt < BUSY;
    endfunction

    function automatic logic [3:0] exp_phase();
        int k;
        if (bt >= BUSY) return 4'b1000;
        k = bt / S;
        return dirl ? (4'b0001 << (2 - k)) : (4'b0001 << k);
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, expv, $time);
        end
    endtask

    task automatic compare();
        chk(step_busy === exp_busy(), "R2 R3 R6 step_busy", int'(step_busy), int'(exp_busy()));
        chk(phase_en === exp_phase(), "R4 R5 R10 phase_en", int'(phase_en), int'(exp_phase()));
        chk(hold_full === (!exp_busy() && it < HOLD), "R7 R9 hold_full",
            int'(hold_full), int'(!exp_busy() && it < HOLD));
        chk(hold_low === (it >= HOLD), "R8 R9 hold_low", int'(hold_low), int'(it >= HOLD));
    endtask

    task automatic cyc(input logic st, input logic d, input logic s, input logic w);
        @(negedge clk);
        compare();
        step_pulse = st; step_dir = d; drv_sel = s; wr_gate = w;
        if (prev && !st && s && !w && bt >= BUSY) begin
            bt = 0; it = 0; dirl = d;
        end else begin
            if (bt < BUSY) bt++;
            if (it < HOLD) it++;
        end
        prev = st;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; step_pulse = 0; step_dir = 0; drv_sel = 0; wr_gate = 0;
        repeat (3) @(negedge clk);
        chk(phase_en === 4'b1000, "R1 reset phase_en", int'(phase_en), 8);
        chk(step_busy === 1'b0, "R1 reset step_busy", int'(step_busy), 0);
        chk(hold_full === 1'b1, "R1 reset hold_full", int'(hold_full), 1);
        chk(hold_low === 1'b0, "R1 reset hold_low", int'(hold_low), 0);
        rst = 1'b0;
        bt = BUSY; it = 1; prev = 1'b0; dirl = 1'b0;
    endtask

    task automatic pulse(input int w, input int gap, input logic d, input logic s, input logic wg);
        for (int i = 0; i < w; i++) cyc(1'b1, d, s, wg);
        for (int i = 0; i < gap; i++) cyc(1'b0, d, s, wg);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog all-R actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d2c3b4a));
        do_reset();
        // R4: inward step, full walk
        pulse(1, BUSY + 4, 1'b0, 1'b1, 1'b0);
        // R5: outward step, direction flipped mid walk
        pulse(2, 10, 1'b1, 1'b1, 1'b0);
        pulse(0, BUSY, 1'b0, 1'b1, 1'b0);
        // R2: deselected and writing pulses ignored
        pulse(1, 10, 1'b0, 1'b0, 1'b0);
        pulse(1, 10, 1'b0, 1'b1, 1'b1);
        // R6: pulses during busy ignored
        pulse(1, 5, 1'b0, 1'b1, 1'b0);
        pulse(1, 5, 1'b1, 1'b1, 1'b0);
        pulse(3, BUSY, 1'b1, 1'b1, 1'b0);
        // R8: long idle to reduced hold, R9: step restores
        pulse(0, HOLD + 10, 1'b0, 1'b1, 1'b0);
        chk(hold_low === 1'b1, "R8 reduced hold after idle", int'(hold_low), 1);
        pulse(4, BUSY + 5, 1'b1, 1'b1, 1'b0);
        chk(hold_full === 1'b1 && hold_low === 1'b0, "R9 full hold after step",
            int'({hold_full, hold_low}), 2);
        // R6: back-to-back right at busy end
        pulse(1, BUSY - 1, 1'b0, 1'b1, 1'b0);
        pulse(1, BUSY + 2, 1'b0, 1'b1, 1'b0);
        // R1: reset in mid walk
        pulse(1, 7, 1'b0, 1'b1, 1'b0);
        do_reset();
        // random mix
        for (int n = 0; n < 400; n++) begin
            int w, g;
            logic d, s, wg;
            w  = 1 + int'($urandom % 3);
            g  = ($urandom % 4 == 0) ? int'($urandom % (HOLD + 30)) : int'($urandom % (BUSY + 8));
            d  = 1'($urandom % 2);
            s  = ($urandom % 6) != 0;
            wg = ($urandom % 6) == 0;
            pulse(w, g, d, s, wg);
        end
        @(negedge clk);
        compare();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule